// File: doc/BRIEF.md
# Effective Address Unit for an 8-bit Accumulator Processor

This unit turns an addressing-mode code and its operand bytes into the 16-bit data address an instruction should use. The instruction decoder starts it with a one-cycle `start` pulse. At the same time the decoder presents the mode, the operand (one byte in bits 7:0, or two bytes little-end first as a 16-bit word), the two index registers and the program-counter base. The unit answers with a one-cycle `done` strobe. While `done` is high, `ea` carries the address and `no_mem` says whether the mode needs one at all.

Direct modes finish in one cycle: page-zero, absolute, their indexed forms and branch targets. The three pointer modes take more cycles. They fetch a two-byte little-endian pointer through a synchronous byte-read port, where data arrives one cycle after the address. With X pre-indexing the index is added before the fetch. With Y post-indexing it is added to the fetched pointer. The absolute-indirect form does a plain two-byte fetch. While a pointer fetch runs, `busy` is high and new starts are dropped.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `no_mem` are 0 and `ea` is 0x0000.
- R2: Mode codes 0, 1, 2 (accumulator, implied, immediate) and the unused codes 13 to 15 give `no_mem`=1 and `ea`=0x0000 when `done` is high.
- R3: Mode 3 (page zero) gives `ea`={0x00, opnd[7:0]}. Modes 4 and 5 add X or Y to opnd[7:0] modulo 256, with the high byte forced to 0x00. For example, 0xFF+1 gives 0x0000.
- R4: Mode 6 (absolute) gives `ea`=opnd. Modes 7 and 8 give (opnd + X or Y) modulo 65536, with the carry going into the high byte.
- R5: Mode 12 (relative) gives `ea`=(pc_base + opnd[7:0] read as a signed byte) modulo 65536.
- R6: A start taken while `busy` is 0 in modes 0 to 8 and 12 to 15 raises `done` for exactly the next cycle. `busy` stays 0 and `rd_en` stays 0.
- R7: Mode 9 (X pre-indexed pointer) reads the low byte at {0x00, (opnd[7:0]+X) mod 256} and the high byte at the next page-zero address, which wraps within page 0x00. The result is `ea`={high, low}.
- R8: Mode 10 (Y post-indexed pointer) reads the low byte at {0x00, opnd[7:0]} and the high byte at {0x00, (opnd[7:0]+1) mod 256}. The result is `ea`=({high, low} + Y) mod 65536.
- R9: Mode 11 (absolute indirect) reads the low byte at opnd and the high byte at (opnd+1) mod 65536. The result is `ea`={high, low} and `no_mem`=0.
- R10: In modes 9 to 11, `rd_en` is 1 in the first and second cycles after the accepting edge, carrying the low address and then the high address. The third cycle has no read. `done` is high in the fourth cycle. `busy` is 1 in cycles one to three and 0 when `done` is high.
- R11: A start while `busy` is 1 is ignored. The running fetch, its result and its timing are unchanged.
- R12: A start presented in the cycle where `done` is high is accepted, so operations run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code |
| opnd | input | 16 | Operand: byte in [7:0] or 16-bit address |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc_base | input | 16 | Base for relative targets |
| rd_en | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result strobe |
| ea | output | 16 | Effective address, held until the next result |
| no_mem | output | 1 | Mode uses no memory address |

## Verification
Two functions can land in the same cycle: finishing a pointer fetch and accepting the next start. The bench provokes this by waiting for `done` and driving a new start in that same cycle, for pointer-to-direct, pointer-to-pointer and direct-to-direct pairs. A behavioural model compares `ea`, `done`, `busy` and the read port on every clock, so the model catches a lost start, a shifted `done` or a corrupted result. The bench also drives starts with different operands in the middle of a fetch. It then judges the running fetch by its read addresses and final address.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int MODE_W = 4;
  localparam int HI_W   = AW - DW;

  typedef logic [AW-1:0]     addr_t;
  typedef logic [DW-1:0]     byte_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t M_ACC  = 4'd0;
  localparam mode_t M_IMP  = 4'd1;
  localparam mode_t M_IMM  = 4'd2;
  localparam mode_t M_ZP   = 4'd3;
  localparam mode_t M_ZPX  = 4'd4;
  localparam mode_t M_ZPY  = 4'd5;
  localparam mode_t M_ABS  = 4'd6;
  localparam mode_t M_ABSX = 4'd7;
  localparam mode_t M_ABSY = 4'd8;
  localparam mode_t M_INDX = 4'd9;
  localparam mode_t M_INDY = 4'd10;
  localparam mode_t M_IND  = 4'd11;
  localparam mode_t M_REL  = 4'd12;

  // place a byte in page zero
  function automatic addr_t page0(byte_t b);
    return {{HI_W{1'b0}}, b};
  endfunction

  // page-zero sum that wraps inside the page
  function automatic addr_t zp_offset(byte_t base, byte_t idx);
    byte_t s;
    s = base + idx;
    return page0(s);
  endfunction

  // full-width indexed sum
  function automatic addr_t abs_offset(addr_t base, byte_t idx);
    return base + page0(idx);
  endfunction

  // branch target with a signed byte displacement
  function automatic addr_t rel_target(addr_t pc, byte_t off);
    return pc + {{HI_W{off[DW-1]}}, off};
  endfunction

  function automatic logic is_ptr(mode_t m);
    return (m == M_INDX) || (m == M_INDY) || (m == M_IND);
  endfunction

  function automatic logic needs_no_addr(mode_t m);
    return (m < M_ZP) || (m > M_REL);
  endfunction
endpackage

// File: rtl/eau_direct.sv
module eau_direct
  import eau_pkg::*;
(
  input  mode_t mode,
  input  addr_t opnd,
  input  byte_t idx_x,
  input  byte_t idx_y,
  input  addr_t pc_base,
  output addr_t d_ea,
  output logic  d_nomem
);
  byte_t op_lo;
  assign op_lo = opnd[DW-1:0];

  always_comb begin
    d_ea    = '0;
    d_nomem = needs_no_addr(mode);
    case (mode)
      M_ZP:    d_ea = page0(op_lo);
      M_ZPX:   d_ea = zp_offset(op_lo, idx_x);
      M_ZPY:   d_ea = zp_offset(op_lo, idx_y);
      M_ABS:   d_ea = opnd;
      M_ABSX:  d_ea = abs_offset(opnd, idx_x);
      M_ABSY:  d_ea = abs_offset(opnd, idx_y);
      M_REL:   d_ea = rel_target(pc_base, op_lo);
      default: d_ea = '0;
    endcase
  end
endmodule

// File: rtl/eau_ptr_seq.sv
module eau_ptr_seq
  import eau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  mode_t mode,
  input  addr_t opnd,
  input  byte_t idx_x,
  input  byte_t idx_y,
  output logic  rd_en,
  output addr_t rd_addr,
  input  byte_t rd_data,
  output logic  busy,
  output logic  fin,
  output addr_t fin_ea
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_FIN} state_e;
  state_e state_q;

  addr_t lo_addr_q, hi_addr_q;
  byte_t post_idx_q, lo_byte_q;
  logic  zp_ptr_q;
  addr_t lo_addr_n, hi_addr_n;
  byte_t post_idx_n;

  logic rd_lo_phase, rd_hi_phase;
  assign rd_lo_phase = (state_q == S_LO);
  assign rd_hi_phase = (state_q == S_HI);

  always_comb begin
    lo_addr_n  = opnd;
    hi_addr_n  = opnd + addr_t'(1);
    post_idx_n = '0;
    case (mode)
      M_INDX: begin
        lo_addr_n = zp_offset(opnd[DW-1:0], idx_x);
        hi_addr_n = zp_offset(lo_addr_n[DW-1:0], byte_t'(1));
      end
      M_INDY: begin
        lo_addr_n  = page0(opnd[DW-1:0]);
        hi_addr_n  = zp_offset(opnd[DW-1:0], byte_t'(1));
        post_idx_n = idx_y;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      lo_addr_q  <= '0;
      hi_addr_q  <= '0;
      post_idx_q <= '0;
      lo_byte_q  <= '0;
      zp_ptr_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (launch) begin
          state_q    <= S_LO;
          lo_addr_q  <= lo_addr_n;
          hi_addr_q  <= hi_addr_n;
          post_idx_q <= post_idx_n;
          zp_ptr_q   <= (mode != M_IND);
        end
        S_LO:  state_q <= S_HI;
        S_HI: begin
          state_q   <= S_FIN;
          lo_byte_q <= rd_data;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_en   = rd_lo_phase | rd_hi_phase;
  assign rd_addr = rd_lo_phase ? lo_addr_q : hi_addr_q;
  assign busy    = (state_q != S_IDLE);
  assign fin     = (state_q == S_FIN);
  assign fin_ea  = abs_offset({rd_data, lo_byte_q}, post_idx_q);

  AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |=> (rd_en && busy)); // R10
  AST_RD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_phase |=> (!rd_en && fin)); // R10
  AST_ZP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && zp_ptr_q) |-> (rd_addr[AW-1:DW] == '0)); // R7
  AST_ZP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_phase && zp_ptr_q) |-> (rd_addr[DW-1:0] == byte_t'($past(rd_addr[DW-1:0]) + 8'd1))); // R8
  AST_IND_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_phase && !zp_ptr_q) |-> (rd_addr == addr_t'($past(rd_addr) + 16'd1))); // R9
endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic [15:0] opnd,
  input  logic [7:0]  idx_x,
  input  logic [7:0]  idx_y,
  input  logic [15:0] pc_base,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  input  logic [7:0]  rd_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] ea,
  output logic        no_mem
);
  addr_t d_ea, fin_ea;
  logic  d_nomem, seq_busy, seq_fin;
  logic  accept, launch, direct_go;

  assign accept    = start && !seq_busy;
  assign launch    = accept && is_ptr(mode);
  assign direct_go = accept && !is_ptr(mode);

  eau_direct u_direct (
    .mode(mode), .opnd(opnd), .idx_x(idx_x), .idx_y(idx_y),
    .pc_base(pc_base), .d_ea(d_ea), .d_nomem(d_nomem)
  );

  eau_ptr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .mode(mode), .opnd(opnd),
    .idx_x(idx_x), .idx_y(idx_y), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(seq_busy), .fin(seq_fin), .fin_ea(fin_ea)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      ea     <= '0;
      no_mem <= 1'b0;
    end else if (direct_go) begin
      done   <= 1'b1;
      ea     <= d_ea;
      no_mem <= d_nomem;
    end else if (seq_fin) begin
      done   <= 1'b1;
      ea     <= fin_ea;
      no_mem <= 1'b0;
    end else begin
      done   <= 1'b0;
    end
  end

  assign busy = seq_busy;

  AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !is_ptr(mode)) |=> (done && !busy && !rd_en)); // R6
  AST_NOMEM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_mem) |-> (ea == '0)); // R2
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !seq_fin) |=> !done); // R11
  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && is_ptr(mode)) |=> busy); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/eff_addr_unit_tb.sv
module eff_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [15:0] opnd = 16'd0;
  logic [7:0]  idx_x = 8'd0, idx_y = 8'd0;
  logic [15:0] pc_base = 16'd0;
  logic        rd_en, busy, done, no_mem;
  logic [15:0] rd_addr, ea;
  logic [7:0]  rd_data = 8'd0;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eff_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opnd(opnd),
    .idx_x(idx_x), .idx_y(idx_y), .pc_base(pc_base), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .ea(ea), .no_mem(no_mem)
  );

  function automatic int memf(int a);
    return ((a % 256) * 13 + (a / 256) * 7 + 108) % 256;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= memf(int'(rd_addr)) & 255;

  function automatic bit ptr_mode(int m);
    return m == 9 || m == 10 || m == 11;
  endfunction

  function automatic string tag_of(int m);
    if (m <= 2 || m >= 13) return "R2";
    if (m <= 5) return "R3";
    if (m <= 8) return "R4";
    if (m == 9) return "R7";
    if (m == 10) return "R8";
    if (m == 11) return "R9";
    return "R5";
  endfunction

  // reference: result, no-address flag and pointer addresses
  task automatic ref_op(input int m, input int op, input int x, input int y, input int pc,
                        output int r, output bit nm, output int lo, output int hi);
    int b, off;
    b = op % 256; nm = 0; r = 0; lo = 0; hi = 0;
    case (m)
      3: r = b;
      4: r = (b + x) % 256;
      5: r = (b + y) % 256;
      6: r = op;
      7: r = (op + x) % 65536;
      8: r = (op + y) % 65536;
      9: begin lo = (b + x) % 256; hi = (lo + 1) % 256; r = memf(hi) * 256 + memf(lo); end
      10: begin lo = b; hi = (b + 1) % 256; r = (memf(hi) * 256 + memf(lo) + y) % 65536; end
      11: begin lo = op; hi = (op + 1) % 65536; r = memf(hi) * 256 + memf(lo); end
      12: begin off = (b >= 128) ? b - 256 : b; r = (pc + off + 65536) % 65536; end
      default: nm = 1;
    endcase
  endtask

  // cycle model
  int ph = 0, m_ea = 0, pend = 0, m_lo = 0, m_hi = 0, m_mode = 0;
  bit m_done = 0, m_nm = 0;
  always @(posedge clk) begin
    int r, lo, hi; bit nm;
    if (!rst_n) begin
      ph = 0; m_done = 0; m_ea = 0; m_nm = 0;
    end else begin
      m_done = 0;
      case (ph)
        0: if (start) begin
          ref_op(mode, opnd, idx_x, idx_y, pc_base, r, nm, lo, hi);
          m_mode = mode;
          if (ptr_mode(mode)) begin ph = 1; pend = r; m_lo = lo; m_hi = hi; end
          else begin m_done = 1; m_ea = r; m_nm = nm; end
        end
        1: ph = 2;
        2: ph = 3;
        default: begin ph = 0; m_done = 1; m_ea = pend; m_nm = 0; end
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    string tt, ta;
    bit e_rd;
    tt = !rst_n ? "R1" : (ptr_mode(m_mode) ? "R10" : "R6");
    ta = !rst_n ? "R1" : tag_of(m_mode);
    e_rd = (ph == 1 || ph == 2);
    chk(tt, "done", done, m_done);
    chk(tt, "busy", busy, ph != 0);
    chk(tt, "rd_en", rd_en, e_rd);
    if (e_rd) chk(ta, "rd_addr", rd_addr, ph == 1 ? m_lo : m_hi);
    chk(ta, "ea", ea, m_ea);
    chk(ta, "no_mem", no_mem, m_nm);
  end

  task automatic drive(input int m, input int op, input int x, input int y, input int pc);
    start = 1; mode = m[3:0]; opnd = op[15:0]; idx_x = x[7:0]; idx_y = y[7:0]; pc_base = pc[15:0];
  endtask

  task automatic run(input int m, input int op, input int x, input int y, input int pc);
    @(negedge clk); drive(m, op, x, y, pc);
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int r, lo, hi; bit nm;
    repeat (3) @(negedge clk);
    chk("R1", "reset ea", ea, 0);
    chk("R1", "reset done", done, 0);
    rst_n = 1;
    // R2 no-address modes
    run(0, 16'h1234, 1, 2, 16'h4000);
    run(1, 16'h00FF, 1, 2, 16'h4000);
    run(2, 16'h0022, 1, 2, 16'h4000);
    run(14, 16'h0099, 1, 2, 16'h4000);
    // R3 page zero
    run(3, 16'h0002, 0, 0, 0);
    run(4, 16'h0001, 2, 0, 0);
    run(4, 16'h00FF, 1, 0, 0);
    run(5, 16'h0001, 0, 3, 0);
    run(5, 16'hAB80, 0, 16'h90, 0);
    // R4 absolute
    run(6, 16'hD010, 5, 5, 0);
    run(7, 16'hC001, 2, 0, 0);
    run(8, 16'hF001, 0, 3, 0);
    run(7, 16'h12FF, 1, 0, 0);
    run(8, 16'hFFFF, 0, 2, 0);
    // R5 relative
    run(12, 16'h002D, 0, 0, 16'hC100);
    run(12, 16'h0080, 0, 0, 16'hC100);
    run(12, 16'h0020, 0, 0, 16'h00F0);
    run(12, 16'h00FF, 0, 0, 16'h0000);
    // R7 R8 R9 pointer modes, with wrap cases
    run(9, 16'h0015, 2, 0, 0);
    run(9, 16'h00FF, 1, 0, 0);
    run(9, 16'h00FE, 1, 0, 0);
    run(10, 16'h002A, 0, 3, 0);
    run(10, 16'h00FF, 0, 8'hF0, 0);
    run(11, 16'h1234, 0, 0, 0);
    run(11, 16'hFFFF, 0, 0, 0);
    // R11 start while busy is ignored
    @(negedge clk); drive(9, 16'h0015, 2, 0, 0);
    @(negedge clk); drive(6, 16'h5555, 0, 0, 0);
    @(negedge clk); drive(10, 16'h0040, 0, 1, 0);
    @(negedge clk); start = 0;
    wait_done();
    ref_op(9, 16'h0015, 2, 0, 0, r, nm, lo, hi);
    chk("R11", "ea after ignored starts", ea, r);
    repeat (4) @(negedge clk);
    // R12 back to back: pointer then direct
    @(negedge clk); drive(10, 16'h002A, 0, 3, 0);
    @(negedge clk); start = 0;
    wait_done(); drive(7, 16'hC001, 2, 0, 0);
    @(negedge clk); start = 0;
    chk("R12", "direct after pointer", ea, 16'hC003);
    // pointer then pointer
    @(negedge clk); drive(11, 16'h3000, 0, 0, 0);
    @(negedge clk); start = 0;
    wait_done(); drive(9, 16'h00FF, 1, 0, 0);
    @(negedge clk); start = 0;
    chk("R12", "second pointer accepted", busy, 1);
    wait_done();
    ref_op(9, 16'h00FF, 1, 0, 0, r, nm, lo, hi);
    chk("R12", "second pointer ea", ea, r);
    // direct then direct
    @(negedge clk); drive(3, 16'h0044, 0, 0, 0);
    @(negedge clk); drive(12, 16'h00FE, 0, 0, 16'h2001);
    @(negedge clk); start = 0;
    chk("R12", "direct pair ea", ea, 16'h1FFF);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule